// File: doc/BRIEF.md
# Dual-Path SPI Serial Clock Divider

This block turns a fast source clock into the serial clock of an SPI bus and tells a companion shift engine, one source cycle at a time, when to launch the next bit and when to capture the incoming one. Two divider paths run side by side. The coarse path divides by four and then by a power of two picked with a 3-bit exponent. The fine path divides by two and then by an 8-bit value plus one, giving even divide ratios in single steps. A select input picks the path. A build parameter can leave the fine path out, and the select input then does nothing.

The serial clock comes from a half-period counter and a toggling phase register, so it always has an even duty cycle and is never a gated copy of the source clock. All settings, including clock polarity and the sampling phase, are copied into shadow registers only while the bus is idle. A burst starts when `run_i` is seen high while idle and ends only at a trailing edge after `run_i` has dropped, so no shortened serial clock pulse can reach the bus.

Top module: `spi_sclk_divider`

## Requirements
- R1: After reset `busy_o`, `shift_stb_o` and `sample_stb_o` are 0 and `sclk_o` is 0 (the shadow polarity resets to 0).
- R2: With `cfg_sel_lin_i` = 0 the full serial clock period is 2^(N+2) source cycles, N being the 3-bit `cfg_pow_exp_i`.
- R3: With `cfg_sel_lin_i` = 1 the full serial clock period is 2*(N+1) source cycles, N being the 8-bit `cfg_lin_div_i`.
- R4: The select input chooses the path: 1 picks the linear path, 0 the power-of-two path.
- R5: When built with `HAS_LINEAR` = 0 the select input and the linear value have no effect; every burst uses the power-of-two ratio.
- R6: The serial clock high time and low time are equal, each half of the full period.
- R7: Divider values, path select, polarity and phase are sampled at the start of a burst; changes while `busy_o` is 1 do not alter the running burst.
- R8: After `run_i` drops, the burst continues to the next trailing edge; `busy_o` falls in the same cycle that `sclk_o` returns to its idle level, so every pulse is full length.
- R9: While idle `sclk_o` equals the polarity input (`cfg_cpol_i`, 1 = idles high), updated one cycle after the input changes.
- R10: Each serial clock edge is marked by exactly one single-cycle strobe, high in the same cycle as the new `sclk_o` value. With `cfg_cpha_i` = 0 the leading edge (away from idle) gives `sample_stb_o` and the trailing edge `shift_stb_o`; with `cfg_cpha_i` = 1 this is swapped.
- R11: The first leading edge appears H source cycles after the clock edge that starts the burst, H being half the full period.

Top module port list below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_i | input | 1 | Request serial clocking; low stops at the next trailing edge |
| cfg_pow_exp_i | input | EXP_W | Exponent N of the power-of-two path |
| cfg_lin_div_i | input | LIN_W | Value N of the linear path |
| cfg_sel_lin_i | input | 1 | 1 selects the linear path |
| cfg_cpol_i | input | 1 | Idle level of the serial clock |
| cfg_cpha_i | input | 1 | 0 samples on leading edges, 1 samples on trailing edges |
| sclk_o | output | 1 | Serial clock |
| shift_stb_o | output | 1 | One-cycle strobe on each launching edge |
| sample_stb_o | output | 1 | One-cycle strobe on each capturing edge |
| busy_o | output | 1 | Burst in progress |

## Verification
Bursts are run on both paths with the smallest ratios (divide by two and by four), mid-range ratios and the largest (512 on both paths), so an off-by-one in either half-period term or a swapped select shows up as a wrong edge spacing. The same stimulus drives a second copy built without the linear path, which separates a select that is honoured from one that is ignored. All four polarity and phase combinations are tried, telling apart strobe placement on leading and trailing edges, and one burst has every setting changed while running, which shows whether the shadow registers really hold. Bursts are stopped both just after a leading and just after a trailing edge to show that shutdown always waits for a full pulse.

// File: rtl/spi_sclk_div_pkg.sv
// Package: shared types for the serial clock divider.
// Assumes nothing beyond IEEE 1800-2017.
package spi_sclk_div_pkg;

    // Bus timing mode held in the shadow registers.
    typedef struct packed {
        logic idle_high;   // serial clock level while idle
        logic late_sample; // 1: capture on trailing edges
    } bus_mode_t;

endpackage

// File: rtl/spi_sclk_div_cfg.sv
// Module: spi_sclk_div_cfg
// Holds shadow copies of the divider settings and turns them into the
// terminal count of the half-period counter. Shadows follow the inputs
// while hold_i is low and freeze while it is high.
// Assumes hold_i rises at the same edge that starts a burst.
module spi_sclk_div_cfg
    import spi_sclk_div_pkg::*;
#(
    parameter int EXP_W      = 3,
    parameter int LIN_W      = 8,
    parameter int CNT_W      = 9,
    parameter bit HAS_LINEAR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [LIN_W-1:0] lin_i,
    input  logic             sel_i,
    input  bus_mode_t        mode_i,
    output logic [CNT_W-1:0] term_o,
    output bus_mode_t        mode_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [EXP_W-1:0] exp_q;
    logic [CNT_W-1:0] pow2_term;
    bus_mode_t        mode_q;

    // Shadow copy of the exponent and bus mode, loaded only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q  <= '0;
            mode_q <= '0;
        end else if (!hold_i) begin
            exp_q  <= exp_i;
            mode_q <= mode_i;
        end
    end

    // Half period of the power-of-two path is 2^(N+1) source cycles.
    always_comb begin
        pow2_term = (ONE << ({1'b0, exp_q} + 1'b1)) - ONE;
    end

    generate
        if (HAS_LINEAR) begin : g_linear
            logic [LIN_W-1:0] lin_q;
            logic             sel_q;

            // Shadow copy of the linear value and path select.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lin_q <= '0;
                    sel_q <= 1'b0;
                end else if (!hold_i) begin
                    lin_q <= lin_i;
                    sel_q <= sel_i;
                end
            end

            // Half period of the linear path is N+1 source cycles.
            always_comb begin
                term_o = sel_q ? CNT_W'(lin_q) : pow2_term;
            end
        end else begin : g_pow2_only
            // Only the power-of-two path exists.
            always_comb begin
                term_o = pow2_term;
            end
        end
    endgenerate

    assign mode_o = mode_q;

    a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && $past(hold_i)) |-> ($stable(term_o) && $stable(mode_o)))
        else $error("a_r7_cfg_frozen: settings moved during a burst");

endmodule

// File: rtl/spi_sclk_div_halfcnt.sv
// Module: spi_sclk_div_halfcnt
// Counts source cycles of each half period, toggles the clock phase at
// the terminal count, and flags leading and trailing edges for one cycle.
// Stops only at a trailing edge, so the phase is back at idle on exit.
// Assumes term_i is stable while active_o is high.
module spi_sclk_div_halfcnt #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] term_i,
    output logic             active_o,
    output logic             phase_o,
    output logic             lead_o,
    output logic             trail_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic             phase_q;
    logic             lead_q;
    logic             trail_q;
    logic             at_term;

    // Terminal count of the current half period.
    always_comb begin
        at_term = (cnt_q == term_i);
    end

    // Burst control, half-period counting and edge flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            phase_q  <= 1'b0;
            lead_q   <= 1'b0;
            trail_q  <= 1'b0;
        end else begin
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
            if (!active_q) begin
                if (run_i) begin
                    active_q <= 1'b1;
                    cnt_q    <= '0;
                    phase_q  <= 1'b0;
                end
            end else if (at_term) begin
                cnt_q   <= '0;
                phase_q <= ~phase_q;
                lead_q  <= ~phase_q;
                trail_q <= phase_q;
                if (phase_q && !run_i) begin
                    active_q <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign phase_o  = phase_q;
    assign lead_o   = lead_q;
    assign trail_o  = trail_q;

    a_r8_stop_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_q) |-> !phase_q)
        else $error("a_r8_stop_at_idle: burst ended mid pulse");

    a_r11_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> (cnt_q == '0 && !phase_q))
        else $error("a_r11_clean_start: burst began with stale count");

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q <= term_i))
        else $error("a_r6_count_bound: half-period counter overran");

endmodule

// File: rtl/spi_sclk_div_strobe.sv
// Module: spi_sclk_div_strobe
// Maps leading and trailing edge flags onto launch and capture strobes
// according to the shadow sampling phase.
// Assumes at most one of lead_i and trail_i is high in any cycle.
module spi_sclk_div_strobe (
    input  logic lead_i,
    input  logic trail_i,
    input  logic late_sample_i,
    output logic shift_o,
    output logic sample_o
);

    // Capture on leading edges unless late sampling is selected.
    always_comb begin
        shift_o  = late_sample_i ? lead_i  : trail_i;
        sample_o = late_sample_i ? trail_i : lead_i;
    end

endmodule

// File: rtl/spi_sclk_divider.sv
// Module: spi_sclk_divider (top)
// Serial clock generator with a power-of-two path and an optional linear
// path, shadowed settings and launch/capture strobes for a shift engine.
// Assumes a single source clock and a synchronous active-low reset.
module spi_sclk_divider
    import spi_sclk_div_pkg::*;
#(
    parameter int EXP_W      = 3,
    parameter int LIN_W      = 8,
    parameter bit HAS_LINEAR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [EXP_W-1:0] cfg_pow_exp_i,
    input  logic [LIN_W-1:0] cfg_lin_div_i,
    input  logic             cfg_sel_lin_i,
    input  logic             cfg_cpol_i,
    input  logic             cfg_cpha_i,
    output logic             sclk_o,
    output logic             shift_stb_o,
    output logic             sample_stb_o,
    output logic             busy_o
);

    localparam int POW_CNT_W = (1 << EXP_W) + 1;
    localparam int LIN_CNT_W = LIN_W + 1;
    localparam int CNT_W     = (POW_CNT_W > LIN_CNT_W) ? POW_CNT_W : LIN_CNT_W;

    bus_mode_t        mode_in;
    bus_mode_t        mode_s;
    logic [CNT_W-1:0] term;
    logic             active;
    logic             phase;
    logic             lead;
    logic             trail;

    // Pack the bus mode inputs.
    always_comb begin
        mode_in.idle_high   = cfg_cpol_i;
        mode_in.late_sample = cfg_cpha_i;
    end

    spi_sclk_div_cfg #(
        .EXP_W      (EXP_W),
        .LIN_W      (LIN_W),
        .CNT_W      (CNT_W),
        .HAS_LINEAR (HAS_LINEAR)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (active),
        .exp_i  (cfg_pow_exp_i),
        .lin_i  (cfg_lin_div_i),
        .sel_i  (cfg_sel_lin_i),
        .mode_i (mode_in),
        .term_o (term),
        .mode_o (mode_s)
    );

    spi_sclk_div_halfcnt #(
        .CNT_W (CNT_W)
    ) u_halfcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_i),
        .term_i   (term),
        .active_o (active),
        .phase_o  (phase),
        .lead_o   (lead),
        .trail_o  (trail)
    );

    spi_sclk_div_strobe u_strobe (
        .lead_i        (lead),
        .trail_i       (trail),
        .late_sample_i (mode_s.late_sample),
        .shift_o       (shift_stb_o),
        .sample_o      (sample_stb_o)
    );

    // Serial clock is the phase register offset by the idle level.
    assign sclk_o = phase ^ mode_s.idle_high;
    assign busy_o = active;

    a_r10_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb_o || sample_stb_o) |-> (sclk_o != $past(sclk_o)))
        else $error("a_r10_strobe_on_edge: strobe without clock edge");

    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> (!shift_stb_o && !sample_stb_o))
        else $error("a_r10_quiet_idle: strobe while idle");

endmodule

// File: tb/spi_sclk_divider_bench.sv
// Bench: behavioural reference model compared every cycle, plus directed
// checks of edge spacing, start latency, shutdown and shadowing.
module spi_sclk_divider_bench;

    localparam int EXP_W = 3;
    localparam int LIN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run = 1'b0;
    logic [EXP_W-1:0] pexp = '0;
    logic [LIN_W-1:0] ldiv = '0;
    logic             sel = 1'b0;
    logic             cpol = 1'b0;
    logic             cpha = 1'b0;
    logic             sclk [2];
    logic             shs  [2];
    logic             sas  [2];
    logic             bsy  [2];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_sclk_divider #(.EXP_W(EXP_W), .LIN_W(LIN_W), .HAS_LINEAR(1'b1)) u_spi_sclk_divider (
        .clk(clk), .rst_n(rst_n), .run_i(run), .cfg_pow_exp_i(pexp),
        .cfg_lin_div_i(ldiv), .cfg_sel_lin_i(sel), .cfg_cpol_i(cpol),
        .cfg_cpha_i(cpha), .sclk_o(sclk[0]), .shift_stb_o(shs[0]),
        .sample_stb_o(sas[0]), .busy_o(bsy[0]));

    spi_sclk_divider #(.EXP_W(EXP_W), .LIN_W(LIN_W), .HAS_LINEAR(1'b0)) u_spi_sclk_divider_nolin (
        .clk(clk), .rst_n(rst_n), .run_i(run), .cfg_pow_exp_i(pexp),
        .cfg_lin_div_i(ldiv), .cfg_sel_lin_i(sel), .cfg_cpol_i(cpol),
        .cfg_cpha_i(cpha), .sclk_o(sclk[1]), .shift_stb_o(shs[1]),
        .sample_stb_o(sas[1]), .busy_o(bsy[1]));

    // Reference model state, index 0 with the linear path, 1 without.
    int m_act[2], m_cnt[2], m_ph[2], m_pol[2], m_cph[2], m_half[2], m_sh[2], m_sa[2];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural model: half period in cycles, edge on its last cycle.
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            m_sh[i] = 0;
            m_sa[i] = 0;
            if (!rst_n) begin
                m_act[i] = 0; m_cnt[i] = 0; m_ph[i] = 0;
                m_pol[i] = 0; m_cph[i] = 0; m_half[i] = 2;
            end else if (m_act[i] == 0) begin
                m_pol[i]  = cpol;
                m_cph[i]  = cpha;
                m_half[i] = (i == 0 && sel) ? int'(ldiv) + 1 : (1 << (int'(pexp) + 1));
                if (run) begin
                    m_act[i] = 1; m_cnt[i] = 0; m_ph[i] = 0;
                end
            end else begin
                m_cnt[i]++;
                if (m_cnt[i] == m_half[i]) begin
                    m_cnt[i] = 0;
                    if (m_ph[i] == m_cph[i]) m_sa[i] = 1; else m_sh[i] = 1;
                    m_ph[i] ^= 1;
                    if (m_ph[i] == 0 && !run) m_act[i] = 0;
                end
            end
        end
    end

    // Cycle-by-cycle comparison against the model, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 2; i++) begin
                check(sclk[i] == 1'((m_ph[i] ^ m_pol[i]) & 1), (i == 0) ? "R6" : "R5",
                      $sformatf("model sclk inst%0d", i), sclk[i], (m_ph[i] ^ m_pol[i]) & 1);
                check(bsy[i] == 1'(m_act[i]), (i == 0) ? "R8" : "R5",
                      $sformatf("model busy inst%0d", i), bsy[i], m_act[i]);
                check(shs[i] == 1'(m_sh[i]) && sas[i] == 1'(m_sa[i]), (i == 0) ? "R10" : "R5",
                      $sformatf("model strobes inst%0d", i), {shs[i], sas[i]}, {m_sh[i][0], m_sa[i][0]});
            end
        end
    end

    // Count negedges until instance 0's serial clock differs from ref.
    task automatic wait_change(input logic ref_lvl, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (sclk[0] == ref_lvl && k < 2000);
    endtask

    // One burst: start, check first edge, spacing, strobes, then stop.
    task automatic burst(input int e, input int l, input bit s, input bit pol,
                         input bit pha, input int nhalf);
        int h, k, stop_wait;
        string rq;
        h  = s ? l + 1 : (1 << (e + 1));
        rq = s ? "R3/R4" : "R2/R4";
        @(negedge clk);
        pexp = EXP_W'(e); ldiv = LIN_W'(l); sel = s; cpol = pol; cpha = pha;
        @(negedge clk);
        check(sclk[0] == pol, "R9", "idle level", sclk[0], pol);
        run = 1'b1;
        wait_change(pol, k);
        check(k == h + 1, "R11", "first edge latency", k, h + 1);
        check(shs[0] == pha && sas[0] == !pha, "R10", "leading-edge strobe",
              {shs[0], sas[0]}, {pha, !pha});
        for (int j = 1; j < nhalf; j++) begin
            logic lvl;
            lvl = sclk[0];
            wait_change(lvl, k);
            check(k == h, rq, "half period (R6 duty)", k, h);
        end
        run = 1'b0;
        stop_wait = (sclk[0] == pol) ? 2 * h : h;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (bsy[0] && k < 2000);
        check(k == stop_wait, "R8", "cycles to stop", k, stop_wait);
        check(sclk[0] == pol, "R8", "level at stop", sclk[0], pol);
        check(shs[0] == !pha && sas[0] == pha, "R10", "trailing-edge strobe",
              {shs[0], sas[0]}, {!pha, pha});
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk[0] == 1'b0 && bsy[0] == 1'b0, "R1", "reset sclk/busy", {sclk[0], bsy[0]}, 0);
        check(shs[0] == 1'b0 && sas[0] == 1'b0, "R1", "reset strobes", {shs[0], sas[0]}, 0);

        burst(0, 0, 1'b0, 1'b0, 1'b0, 4);
        burst(3, 0, 1'b0, 1'b1, 1'b0, 5);
        burst(7, 0, 1'b0, 1'b0, 1'b1, 3);
        burst(2, 0, 1'b1, 1'b0, 1'b0, 6);
        burst(1, 5, 1'b1, 1'b1, 1'b1, 4);
        burst(0, 255, 1'b1, 1'b0, 1'b1, 3);
        burst(4, 6, 1'b1, 1'b1, 1'b0, 5);

        // R7: change every setting mid-burst; old ratio and mode must hold.
        @(negedge clk);
        pexp = 3'd1; ldiv = 8'd3; sel = 1'b1; cpol = 1'b0; cpha = 1'b1;
        @(negedge clk);
        run = 1'b1;
        wait_change(1'b0, k);
        pexp = 3'd6; ldiv = 8'd40; sel = 1'b0; cpol = 1'b1; cpha = 1'b0;
        for (int j = 0; j < 3; j++) begin
            logic lvl;
            lvl = sclk[0];
            wait_change(lvl, k);
            check(k == 4, "R7", "half period after change", k, 4);
        end
        run = 1'b0;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (bsy[0] && k < 2000);
        check(sclk[0] == 1'b0, "R7", "old polarity at stop", sclk[0], 0);
        check(sas[0] == 1'b1, "R7", "old phase at stop strobe", sas[0], 1);
        @(negedge clk);
        check(sclk[0] == 1'b1, "R9", "new idle level", sclk[0], 1);

        // R5: select set, copy without linear path keeps power-of-two ratio.
        pexp = 3'd1; ldiv = 8'd0; sel = 1'b1; cpol = 1'b0; cpha = 1'b0;
        @(negedge clk);
        run = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (sclk[1] == 1'b0 && k < 2000);
        check(k == 5, "R5", "no-linear first edge", k, 5);
        run = 1'b0;
        repeat (20) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failure and still reports the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule